// File: doc/BRIEF.md
# Debug Halt Controller

This block decides when a processor core has to stop and hand control to a debugger, and it holds the core in that halted state until the debugger lets it go. Eight kinds of halt request feed one merge point: software breakpoint instructions, hardware breakpoint/watchpoint hits, a rising edge on an external break input, a break-now control bit, traps that would send the core to error mode, traps chosen through a class mask, single-step completion, and breakpoint hits from the debug unit. A hardware enable input gates all of them. While the enable is low the core cannot be halted.

When a request is accepted, the block copies the core's PC and next-PC into holding registers and raises both a pipeline hold and a debug-active output. A bus master reaches the block through a 2 MiB window. The control register can be used at any time. The saved PC and next-PC can be used only while the core is halted. A resume bit in the control register releases the core. A step-mode bit lets the core run for a short time and then brings it back into debug mode.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `dbgEnable` is low at a clock edge, no halt source causes entry into debug mode at that edge.
- R2: With `dbgEnable` high and the core running, a pulse on `swBreak`, `hwWatchHit`, `errTrap` or `duBreakHit` puts the core into debug mode at the next clock edge.
- R3: `extBreak` causes entry only on a low-to-high transition that is seen while enabled. Holding it high, whether after a resume or while the enable rises, causes no further entry.
- R4: The trap mask sits in control bits [15:8], with class n at bit 8+n. A `trapValid` pulse halts the core only when the bit for its `trapClass` is set.
- R5: On entry, `savedPc` and `savedNpc` take the values that `curPc` and `curNpc` had in the cycle of the request.
- R6: `pipeHold` and `debugActive` are both high for the whole time the core is halted, including while halt sources stay active, and both are low while it runs.
- R7: The saved PC (offset 0x4) and saved next-PC (offset 0x8) can be read and written only in debug mode. Outside debug mode a read returns zero and a write changes nothing.
- R8: The control register (offset 0x0) can be read and written in any mode. Writing 1 to bit 1 (resume) while halted clears debug mode at the next clock edge. Bit 1 always reads as 0.
- R9: Bit 0 (break-now) halts the core once it is set, and it clears itself at the edge where debug mode is entered.
- R10: With bit 2 (step) set, the first `retirePulse` after a resume passes and the second one halts the core. With step clear, retires never halt the core.
- R11: An access counts only when `busAddr[31:21]` matches the window base and the offset is word-aligned and mapped. Any other access has no effect and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgEnable | input | 1 | Hardware enable for all halt sources |
| extBreak | input | 1 | External break request, edge sensitive |
| swBreak | input | 1 | Software breakpoint instruction executed |
| hwWatchHit | input | 1 | Hardware breakpoint/watchpoint trap |
| errTrap | input | 1 | Trap that would enter error mode |
| trapValid | input | 1 | A trap of class `trapClass` is taken |
| trapClass | input | 3 | Class of the current trap |
| duBreakHit | input | 1 | Debug-unit breakpoint hit |
| retirePulse | input | 1 | One instruction retired |
| curPc | input | 32 | Current program counter |
| curNpc | input | 32 | Current next program counter |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| pipeHold | output | 1 | Holds the core pipeline |
| debugActive | output | 1 | Debug state indicator |
| savedPc | output | 32 | PC captured on entry |
| savedNpc | output | 32 | Next-PC captured on entry |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, eight trap classes, and a window at 0x9000_0000. With these values the full mask field is present, so a set class and a clear class can be checked against each other. Addresses outside the 2 MiB window can also be exercised, for example 0x1000_0000. A 32-bit PC shows whether the capture and the bus write paths keep every bit.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int CTRL_BREAK_BIT  = 0;
  localparam int CTRL_RESUME_BIT = 1;
  localparam int CTRL_STEP_BIT   = 2;
  localparam int CTRL_MASK_LSB   = 8;
  localparam int WIN_LSB         = 21;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PC   = 2'd1,
    REG_NPC  = 2'd2,
    REG_NONE = 2'd3
  } regIdx_e;

  typedef struct packed {
    logic saveState;
    logic wrPc;
    logic wrNpc;
    logic rdCtrl;
    logic rdPc;
    logic rdNpc;
  } dpStrobe_t;
endpackage

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int TRAP_CLASSES = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9000_0000
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            dbgEnable,
  input  logic                            extBreak,
  input  logic                            swBreak,
  input  logic                            hwWatchHit,
  input  logic                            errTrap,
  input  logic                            trapValid,
  input  logic [$clog2(TRAP_CLASSES)-1:0] trapClass,
  input  logic                            duBreakHit,
  input  logic                            retirePulse,
  input  logic                            busSel,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  output logic                            dbgMode,
  output logic [DATA_W-1:0]               ctrlWord,
  output dpStrobe_t                       strb
);
  localparam logic [DATA_W-1:0] WR_MASK =
      (DATA_W'((1 << TRAP_CLASSES) - 1) << CTRL_MASK_LSB)
    | (DATA_W'(1) << CTRL_BREAK_BIT)
    | (DATA_W'(1) << CTRL_STEP_BIT);

  logic              dbgModeQ, extPrevQ, stepSeenQ;
  logic [DATA_W-1:0] ctrlQ, ctrlD;
  logic              winHit, accessCtrl, accessPc, accessNpc, wrCtrl;
  logic              resumeReq, extRise, trapHit, stepHit, anySrc, enterReq;
  regIdx_e           regIdx;

  // Address decode: upper bits select the window, low bits the register
  always_comb begin
    winHit = busSel
          && (busAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB])
          && (busAddr[WIN_LSB-1:4] == '0)
          && (busAddr[1:0] == 2'b00);
    regIdx = regIdx_e'(busAddr[3:2]);
  end

  assign accessCtrl = winHit && (regIdx == REG_CTRL);
  assign accessPc   = winHit && (regIdx == REG_PC)  && dbgModeQ;
  assign accessNpc  = winHit && (regIdx == REG_NPC) && dbgModeQ;
  assign wrCtrl     = accessCtrl && busWrite;
  assign resumeReq  = wrCtrl && busWdata[CTRL_RESUME_BIT] && dbgModeQ;

  // Merge of halt sources
  assign extRise  = extBreak && !extPrevQ;
  assign trapHit  = trapValid && ctrlQ[CTRL_MASK_LSB + int'(trapClass)];
  assign stepHit  = ctrlQ[CTRL_STEP_BIT] && stepSeenQ && retirePulse;
  assign anySrc   = swBreak || hwWatchHit || extRise || ctrlQ[CTRL_BREAK_BIT]
                 || errTrap || trapHit || stepHit || duBreakHit;
  assign enterReq = dbgEnable && !dbgModeQ && anySrc;

  always_comb begin
    ctrlD = wrCtrl ? (busWdata & WR_MASK) : ctrlQ;
    if (enterReq) ctrlD[CTRL_BREAK_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgModeQ  <= 1'b0;
      extPrevQ  <= 1'b0;
      stepSeenQ <= 1'b0;
      ctrlQ     <= '0;
    end else begin
      extPrevQ <= extBreak;
      ctrlQ    <= ctrlD;
      if (enterReq)       dbgModeQ <= 1'b1;
      else if (resumeReq) dbgModeQ <= 1'b0;
      if (dbgModeQ)                                stepSeenQ <= 1'b0;
      else if (retirePulse && ctrlQ[CTRL_STEP_BIT]) stepSeenQ <= 1'b1;
    end
  end

  assign dbgMode  = dbgModeQ;
  assign ctrlWord = ctrlQ;
  always_comb begin
    strb.saveState = enterReq;
    strb.wrPc      = accessPc  && busWrite;
    strb.wrNpc     = accessNpc && busWrite;
    strb.rdCtrl    = accessCtrl;
    strb.rdPc      = accessPc;
    strb.rdNpc     = accessNpc;
  end

  p_enable_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgModeQ) |-> $past(dbgEnable));
  p_direct_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEnable && !dbgModeQ && (swBreak || hwWatchHit || errTrap || duBreakHit)) |=> dbgModeQ);
  p_halted_stays_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dbgModeQ && !(busSel && busWrite)) |=> dbgModeQ);
  p_resume_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dbgModeQ && busSel && busWrite && busAddr == WIN_BASE && busWdata[CTRL_RESUME_BIT]) |=> !dbgModeQ);
  p_break_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgModeQ) |-> !ctrlQ[CTRL_BREAK_BIT]);
endmodule

// File: rtl/dbg_halt_dp.sv
module dbg_halt_dp
  import dbg_halt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] curNpc,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] savedPc,
  output logic [DATA_W-1:0] savedNpc
);
  logic [DATA_W-1:0] savedPcQ, savedNpcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPcQ  <= '0;
      savedNpcQ <= '0;
    end else begin
      if (strb.saveState)  savedPcQ  <= curPc;
      else if (strb.wrPc)  savedPcQ  <= busWdata;
      if (strb.saveState)  savedNpcQ <= curNpc;
      else if (strb.wrNpc) savedNpcQ <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdCtrl) busRdata = ctrlWord;
    if (strb.rdPc)   busRdata = savedPcQ;
    if (strb.rdNpc)  busRdata = savedNpcQ;
  end

  assign savedPc  = savedPcQ;
  assign savedNpc = savedNpcQ;

  p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveState |=> (savedPcQ == $past(curPc)) && (savedNpcQ == $past(curNpc)));
  p_state_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.saveState && !strb.wrPc && !strb.wrNpc) |=> $stable(savedPcQ) && $stable(savedNpcQ));
  p_one_reader_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdCtrl, strb.rdPc, strb.rdNpc}));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int TRAP_CLASSES = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9000_0000,
  localparam int CLS_W = $clog2(TRAP_CLASSES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEnable,
  input  logic              extBreak,
  input  logic              swBreak,
  input  logic              hwWatchHit,
  input  logic              errTrap,
  input  logic              trapValid,
  input  logic [CLS_W-1:0]  trapClass,
  input  logic              duBreakHit,
  input  logic              retirePulse,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] curNpc,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pipeHold,
  output logic              debugActive,
  output logic [DATA_W-1:0] savedPc,
  output logic [DATA_W-1:0] savedNpc
);
  logic              dbgMode;
  logic [DATA_W-1:0] ctrlWord;
  dpStrobe_t         strb;

  dbg_halt_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRAP_CLASSES(TRAP_CLASSES), .WIN_BASE(WIN_BASE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .extBreak(extBreak),
    .swBreak(swBreak), .hwWatchHit(hwWatchHit), .errTrap(errTrap),
    .trapValid(trapValid), .trapClass(trapClass), .duBreakHit(duBreakHit),
    .retirePulse(retirePulse), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .dbgMode(dbgMode),
    .ctrlWord(ctrlWord), .strb(strb)
  );

  dbg_halt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curPc(curPc), .curNpc(curNpc),
    .busWdata(busWdata), .ctrlWord(ctrlWord), .busRdata(busRdata),
    .savedPc(savedPc), .savedNpc(savedNpc)
  );

  assign pipeHold    = dbgMode;
  assign debugActive = dbgMode;
endmodule

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h9000_0000;
  localparam logic [31:0] MASK = 32'h0000_0800;  // class 3 enabled

  logic clk = 1'b0, rstN = 1'b0;
  logic dbgEnable = 1'b0, extBreak = 1'b0, swBreak = 1'b0, hwWatchHit = 1'b0;
  logic errTrap = 1'b0, trapValid = 1'b0, duBreakHit = 1'b0, retirePulse = 1'b0;
  logic [2:0]  trapClass = '0;
  logic [31:0] curPc = '0, curNpc = '0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] busRdata, savedPc, savedNpc;
  logic pipeHold, debugActive;
  int checks = 0, fails = 0;
  logic [31:0] rd;

  dbg_halt_ctrl u_dbg_halt_ctrl (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .extBreak(extBreak),
    .swBreak(swBreak), .hwWatchHit(hwWatchHit), .errTrap(errTrap),
    .trapValid(trapValid), .trapClass(trapClass), .duBreakHit(duBreakHit),
    .retirePulse(retirePulse), .curPc(curPc), .curNpc(curNpc),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pipeHold(pipeHold), .debugActive(debugActive),
    .savedPc(savedPc), .savedNpc(savedNpc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {source[2:0], enable, expectHalt}; sources: 0 sw,1 hw,2 err,3 du,4 trap cls3,5 trap cls5
  localparam logic [4:0] VEC [9] = '{
    {3'd0,1'b1,1'b1}, {3'd1,1'b1,1'b1}, {3'd2,1'b1,1'b1}, {3'd3,1'b1,1'b1},
    {3'd4,1'b1,1'b1}, {3'd5,1'b1,1'b0}, {3'd0,1'b0,1'b0}, {3'd2,1'b0,1'b0},
    {3'd4,1'b0,1'b0}};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [31:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic resume(input logic [31:0] keep);
    busWr(BASE, keep | 32'h2);
  endtask

  task automatic pulseSw();
    @(negedge clk); swBreak = 1'b1;
    @(negedge clk); swBreak = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R6 reset debugActive", {31'd0, debugActive}, 32'd0);
    check("R6 reset pipeHold", {31'd0, pipeHold}, 32'd0);
    check("R5 reset savedPc", savedPc, 32'd0);
    busRd(BASE, rd); check("R8 reset ctrl", rd, 32'd0);

    dbgEnable = 1'b1;
    busWr(BASE, MASK);
    busRd(BASE, rd); check("R8 ctrl readback running", rd, MASK);

    // table walk
    for (int i = 0; i < 9; i++) begin
      string tag;
      tag = (VEC[i][4:2] >= 3'd4) ? "R4 trap mask" : (!VEC[i][1] ? "R1 enable gate" : "R2 source");
      @(negedge clk);
      dbgEnable = VEC[i][1];
      case (VEC[i][4:2])
        3'd0: swBreak = 1'b1;
        3'd1: hwWatchHit = 1'b1;
        3'd2: errTrap = 1'b1;
        3'd3: duBreakHit = 1'b1;
        3'd4: begin trapValid = 1'b1; trapClass = 3'd3; end
        default: begin trapValid = 1'b1; trapClass = 3'd5; end
      endcase
      @(negedge clk);
      {swBreak, hwWatchHit, errTrap, duBreakHit, trapValid} = '0;
      check(tag, {31'd0, debugActive}, {31'd0, VEC[i][0]});
      check({tag, " R6 hold"}, {31'd0, pipeHold}, {31'd0, VEC[i][0]});
      dbgEnable = 1'b1;
      if (VEC[i][0]) begin
        resume(MASK);
        check("R8 resume", {31'd0, debugActive}, 32'd0);
      end
    end

    // capture and mode-qualified state access
    curPc = 32'h1234_5670; curNpc = 32'h1234_5674;
    pulseSw();
    curPc = 32'h0; curNpc = 32'h0;
    check("R5 savedPc", savedPc, 32'h1234_5670);
    check("R5 savedNpc", savedNpc, 32'h1234_5674);
    busRd(BASE + 32'h4, rd); check("R7 read pc halted", rd, 32'h1234_5670);
    busRd(BASE + 32'h8, rd); check("R7 read npc halted", rd, 32'h1234_5674);
    busWr(BASE + 32'h4, 32'hAAAA_0000);
    busRd(BASE + 32'h4, rd); check("R7 write pc halted", rd, 32'hAAAA_0000);
    repeat (3) @(negedge clk);
    check("R6 stays halted", {31'd0, debugActive}, 32'd1);
    resume(MASK);
    busRd(BASE + 32'h4, rd); check("R7 read pc running", rd, 32'd0);
    busWr(BASE + 32'h4, 32'h0000_5555);
    check("R7 write pc running ignored", savedPc, 32'hAAAA_0000);

    // break-now bit
    busWr(BASE, MASK | 32'h1);
    @(negedge clk);
    check("R9 break-now entry", {31'd0, debugActive}, 32'd1);
    busRd(BASE, rd); check("R9 break-now cleared", rd, MASK);
    resume(MASK);
    repeat (2) @(negedge clk);
    check("R9 no re-entry", {31'd0, debugActive}, 32'd0);

    // window decode
    busWr(32'h1000_0000, MASK | 32'h1);
    repeat (2) @(negedge clk);
    check("R11 outside window", {31'd0, debugActive}, 32'd0);
    busRd(32'h1000_0000, rd); check("R11 outside read", rd, 32'd0);
    busRd(BASE, rd); check("R11 ctrl unchanged", rd, MASK);

    // external break edge
    @(negedge clk); extBreak = 1'b1;
    @(negedge clk);
    check("R3 ext rise", {31'd0, debugActive}, 32'd1);
    resume(MASK);
    repeat (3) @(negedge clk);
    check("R3 ext held no re-entry", {31'd0, debugActive}, 32'd0);
    extBreak = 1'b0; dbgEnable = 1'b0;
    @(negedge clk); extBreak = 1'b1;
    @(negedge clk);
    check("R1 ext rise disabled", {31'd0, debugActive}, 32'd0);
    dbgEnable = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 enable rise with ext held", {31'd0, debugActive}, 32'd0);
    extBreak = 1'b0;
    @(negedge clk); extBreak = 1'b1;
    @(negedge clk);
    check("R3 second rise", {31'd0, debugActive}, 32'd1);
    extBreak = 1'b0;
    resume(MASK);

    // single step
    pulseSw();
    busWr(BASE, MASK | 32'h6);
    check("R10 step resume", {31'd0, debugActive}, 32'd0);
    @(negedge clk); retirePulse = 1'b1;
    @(negedge clk); retirePulse = 1'b0;
    check("R10 first retire passes", {31'd0, debugActive}, 32'd0);
    @(negedge clk); retirePulse = 1'b1;
    @(negedge clk); retirePulse = 1'b0;
    check("R10 second retire halts", {31'd0, debugActive}, 32'd1);
    resume(MASK);
    repeat (2) begin
      @(negedge clk); retirePulse = 1'b1;
      @(negedge clk); retirePulse = 1'b0;
    end
    check("R10 step off", {31'd0, debugActive}, 32'd0);

    summary();
  end
endmodule